// File: doc/BRIEF.md
# Bipolar Line Code Violation Detector

This block watches a received bipolar line and raises a one-cycle pulse for every code violation it finds. The line arrives as two mark inputs, one for positive pulses and one for negative pulses, qualified by a bit strobe. A mode input selects the line code. Only the two bipolar codes are checked: alternate mark inversion (AMI) and AMI with bipolar eight-zero substitution (B8ZS). The two-level codes, NRZ and CMI, never produce a pulse.

In AMI mode any mark that repeats the polarity of the mark before it is a violation. In B8ZS mode the detector first looks for the eight-bit substitution group and removes the two deliberate violations inside it. Any other violation is still reported. An enable input adds excessive-zero checking. The allowed zero run is 7 bits under B8ZS and 15 bits under AMI, and each run that exceeds the limit is reported once.

Every bit goes through an eight-strobe delay line. This gives the detector time to see a whole substitution group before it releases a verdict on any bit in it. The pulses feed an external error counter. Decoding, clock recovery and counting are done outside this block.

Top module: `lcv_detector`

## Requirements
- R1: The mode input is coded as 00 NRZ, 01 CMI, 10 AMI and 11 B8ZS. In NRZ and CMI modes no pulse is ever produced, whatever the marks, zero runs or enable.
- R2: In AMI mode, every mark with the same polarity as the previous mark is flagged. This includes the marks of a group shaped like a substitution.
- R3: The first mark after reset is never flagged, whatever its polarity.
- R4: A bit with both mark inputs high counts as one positive mark.
- R5: In B8ZS mode, the two violations of a group 0,0,0,V,B,0,V,B are not flagged. V repeats the polarity of the preceding mark and B alternates. The mark that follows the group is checked against the group's last mark.
- R6: In B8ZS mode, every violation outside a complete substitution group is flagged. This includes the violations of a group whose final mark is missing.
- R7: With the zero check enabled in B8ZS mode, the 8th zero of a run is flagged and a run of 7 zeros is not.
- R8: With the zero check enabled in AMI mode, the 16th zero of a run is flagged and a run of 15 zeros is not.
- R9: With the zero check disabled, zero runs of any length are never flagged.
- R10: A zero run produces exactly one pulse, however far it continues past the limit.
- R11: The pulse for a bit appears in the single cycle that follows the 8th bit strobe after that bit's own strobe. The output is low in every cycle that does not follow a strobe.
- R12: Reset clears all state. The output is low during reset and right after it, and flags still pending when reset arrives are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Bit strobe; the mark inputs are valid in this cycle |
| pos_in | input | 1 | Positive mark received |
| neg_in | input | 1 | Negative mark received |
| code_sel | input | 2 | Line code: 00 NRZ, 01 CMI, 10 AMI, 11 B8ZS |
| exz_en | input | 1 | Enables the excessive-zero check |
| viol_o | output | 1 | One-cycle pulse for each violation |

## Verification
The bench builds the detector with its default parameters: zero limits of 7 and 15 and a delay of eight strobes. With these values, both zero limits can be reached with runs of up to 22 zeros, and runs one zero short show where each limit lies. The eight-strobe delay is short enough that complete, broken and AMI-coded substitution groups each fit in one short vector. A directed test with idle cycles between strobes confirms that the delay is counted in strobes rather than clock cycles.

// File: rtl/lcv_pkg.sv
// Shared types for the line code violation detector.
// Assumes the mode codes below are fixed by the surrounding receiver.
package lcv_pkg;

    typedef enum logic [1:0] {
        LC_NRZ  = 2'b00,
        LC_CMI  = 2'b01,
        LC_AMI  = 2'b10,
        LC_B8ZS = 2'b11
    } line_code_e;

    // Length of the eight-zero substitution group.
    localparam int SUB_LEN = 8;

    // Group shape by bit age (bit 0 = newest bit, bit 7 = oldest bit).
    // Marks sit at ages 0,1,3,4; the violations sit at ages 1 and 4.
    localparam logic [SUB_LEN-1:0] SUB_MARK = 8'b0001_1011;
    localparam logic [SUB_LEN-1:0] SUB_VIOL = 8'b0001_0010;

    function automatic logic is_bipolar(input line_code_e c);
        return (c == LC_AMI) || (c == LC_B8ZS);
    endfunction

endpackage

// File: rtl/lcv_mark_track.sv
// Keeps the polarity of the most recent mark and reports a raw bipolar
// violation: a mark that repeats the previous mark's polarity.
// Assumes the polarity input is valid whenever the mark input is high.
// The first mark after reset is never a violation.
module lcv_mark_track (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic mark,
    input  logic pol,
    output logic raw_viol
);

    logic last_pol;
    logic seen_mark;

    // Remember the polarity of the last mark and whether any mark has been seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_pol  <= 1'b0;
            seen_mark <= 1'b0;
        end else if (bit_en && mark) begin
            last_pol  <= pol;
            seen_mark <= 1'b1;
        end
    end

    // Flag a repeated polarity, but only once a previous mark exists.
    always_comb begin
        raw_viol = mark && seen_mark && (pol == last_pol);
    end

endmodule

// File: rtl/lcv_zero_run.sv
// Counts consecutive zeros and raises one hit at the bit whose zero makes
// the run exceed the limit for the current bipolar code.
// Assumes both limits are below the counter's saturation value.
module lcv_zero_run
    import lcv_pkg::*;
#(
    parameter int B8ZS_ZMAX = 7,
    parameter int AMI_ZMAX  = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       mark,
    input  line_code_e code,
    input  logic       exz_en,
    output logic       exz_hit
);

    localparam int ZTOP  = (B8ZS_ZMAX > AMI_ZMAX) ? B8ZS_ZMAX : AMI_ZMAX;
    localparam int CNT_W = $clog2(ZTOP + 2);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(ZTOP + 1);

    logic [CNT_W-1:0] zcnt;
    logic [CNT_W-1:0] limit;

    // Count zeros, restart on any mark, and saturate above both limits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zcnt <= '0;
        end else if (bit_en) begin
            if (mark)
                zcnt <= '0;
            else if (zcnt != CNT_SAT)
                zcnt <= zcnt + 1'b1;
        end
    end

    // Hit when this zero is one past the allowed run for the current code.
    always_comb begin
        limit   = (code == LC_B8ZS) ? CNT_W'(B8ZS_ZMAX) : CNT_W'(AMI_ZMAX);
        exz_hit = bit_en && exz_en && is_bipolar(code) && !mark && (zcnt == limit);
    end

endmodule

// File: rtl/lcv_subst_filter.sv
// Holds per-bit error flags in a delay line of DEPTH strobes.
// It matches the newest bit plus seven bits of history against the
// substitution group and, in B8ZS mode, clears the flags of the group's
// two deliberate violations. The flag leaving the line becomes the output
// pulse. Assumes DEPTH >= 5 so that the oldest cleared flag is still held
// when the group completes.
module lcv_subst_filter
    import lcv_pkg::*;
#(
    parameter int DEPTH = SUB_LEN
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       mark,
    input  logic       raw_viol,
    input  line_code_e code,
    input  logic       exz_hit,
    output logic       pipe_head,
    output logic       viol_o
);

    localparam int HIST = SUB_LEN - 1;

    logic [HIST-1:0]  hist_mark;
    logic [HIST-1:0]  hist_viol;
    logic [DEPTH-1:0] flags;
    logic [DEPTH-1:0] flags_kept;
    logic             sub_match;
    logic             new_flag;

    // Shift the mark and raw-violation history by one bit per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_mark <= '0;
            hist_viol <= '0;
        end else if (bit_en) begin
            hist_mark <= {hist_mark[HIST-2:0], mark};
            hist_viol <= {hist_viol[HIST-2:0], raw_viol};
        end
    end

    // Match the complete substitution group ending at the newest bit.
    always_comb begin
        sub_match = (code == LC_B8ZS)
                 && ({hist_mark, mark}     == SUB_MARK)
                 && ({hist_viol, raw_viol} == SUB_VIOL);
        new_flag  = (is_bipolar(code) && raw_viol) || exz_hit;
    end

    // Clear the held flag at every history age where the group has a violation.
    for (genvar k = 0; k < DEPTH; k++) begin : g_keep
        if (k < HIST && SUB_VIOL[k+1]) begin : g_sub
            assign flags_kept[k] = flags[k] && !sub_match;
        end else begin : g_pass
            assign flags_kept[k] = flags[k];
        end
    end

    // Advance the delay line and emit the flag that leaves it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags  <= '0;
            viol_o <= 1'b0;
        end else if (bit_en) begin
            flags  <= {flags_kept[DEPTH-2:0], new_flag};
            viol_o <= flags[DEPTH-1];
        end else begin
            viol_o <= 1'b0;
        end
    end

    assign pipe_head = flags[0];

endmodule

// File: rtl/lcv_detector.sv
// Top level of the bipolar line code violation detector.
// It decodes the two mark inputs, tracks the last mark's polarity, checks
// zero runs and filters out substitution violations, then emits one pulse
// per violation DEPTH strobes after the offending bit.
// Assumes bit_en is a one-cycle strobe per received bit.
module lcv_detector
    import lcv_pkg::*;
#(
    parameter int B8ZS_ZMAX = 7,
    parameter int AMI_ZMAX  = 15,
    parameter int DEPTH     = SUB_LEN
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       pos_in,
    input  logic       neg_in,
    input  logic [1:0] code_sel,
    input  logic       exz_en,
    output logic       viol_o
);

    line_code_e code;
    logic       mark;
    logic       pol;
    logic       raw_viol;
    logic       exz_hit;
    logic       pipe_head;

    // Any mark input makes a mark; the positive input sets its polarity.
    always_comb begin
        code = line_code_e'(code_sel);
        mark = pos_in || neg_in;
        pol  = pos_in;
    end

    lcv_mark_track u_mark (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .mark     (mark),
        .pol      (pol),
        .raw_viol (raw_viol)
    );

    lcv_zero_run #(
        .B8ZS_ZMAX (B8ZS_ZMAX),
        .AMI_ZMAX  (AMI_ZMAX)
    ) u_zero (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .mark    (mark),
        .code    (code),
        .exz_en  (exz_en),
        .exz_hit (exz_hit)
    );

    lcv_subst_filter #(
        .DEPTH (DEPTH)
    ) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .mark      (mark),
        .raw_viol  (raw_viol),
        .code      (code),
        .exz_hit   (exz_hit),
        .pipe_head (pipe_head),
        .viol_o    (viol_o)
    );

endmodule

// File: rtl/lcv_detector_chk.sv
// Checker for the line code violation detector. It relates the stages of
// the detector to one another and to its ports over time.
module lcv_detector_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic [1:0] code_sel,
    input logic       mark,
    input logic       raw_viol,
    input logic       exz_hit,
    input logic       pipe_head,
    input logic       viol_o
);

    // R11
    pulse_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> $past(bit_en));

    // R1
    code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !code_sel[1]) |=> !pipe_head);

    // R2
    ami_flag_enters_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && code_sel == 2'b10 && raw_viol) |=> pipe_head);

    // R10
    exz_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exz_hit |=> !exz_hit);

    // R7
    exz_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exz_hit |-> !mark);

    // R12
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !viol_o);

endmodule

bind lcv_detector lcv_detector_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .code_sel  (code_sel),
    .mark      (mark),
    .raw_viol  (raw_viol),
    .exz_hit   (exz_hit),
    .pipe_head (pipe_head),
    .viol_o    (viol_o)
);

// File: tb/lcv_detector_test.sv
// Bench for the line code violation detector: a vector table walked by
// one loop, followed by directed reset and strobe-gap tests.
module lcv_detector_test;

    localparam int DLY = 8;   // pulse latency in strobes (R11)
    localparam int NV  = 20;

    typedef struct packed {
        logic [23:0]  tag;
        logic [1:0]   md;
        logic         ez;
        logic [255:0] pat;    // '+' pos, '-' neg, '*' both, '0' zero
        logic [255:0] exp;    // '^' flagged bit, '.' clean bit
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{"R1 ", 2'b00, 1'b1, "++--0000000000000000", "...................."},
        '{"R1 ", 2'b01, 1'b1, "++--0000000000000000", "...................."},
        '{"R2 ", 2'b10, 1'b0, "+-+-0+-",              "......."},
        '{"R2 ", 2'b10, 1'b0, "+-++0-+--",            "...^....^"},
        '{"R3 ", 2'b10, 1'b0, "++",                   ".^"},
        '{"R3 ", 2'b10, 1'b0, "--",                   ".^"},
        '{"R4 ", 2'b10, 1'b0, "-*+-",                 "..^."},
        '{"R4 ", 2'b10, 1'b0, "+*",                   ".^"},
        '{"R5 ", 2'b11, 1'b0, "+000+-0-+-",           ".........."},
        '{"R5 ", 2'b11, 1'b1, "-000-+0+-+",           ".........."},
        '{"R6 ", 2'b11, 1'b0, "+000+-0-0",            "....^..^."},
        '{"R6 ", 2'b11, 1'b0, "+-+-++",               ".....^"},
        '{"R2 ", 2'b10, 1'b0, "+000+-0-+",            "....^..^."},
        '{"R7 ", 2'b11, 1'b1, "+0000000-",            "........."},
        '{"R7 ", 2'b11, 1'b1, "+00000000-",           "........^."},
        '{"R8 ", 2'b10, 1'b1, "+000000000000000-",    "................."},
        '{"R8 ", 2'b10, 1'b1, "+0000000000000000-",   "................^."},
        '{"R10", 2'b10, 1'b1, "+0000000000000000000000-", "................^......."},
        '{"R9 ", 2'b10, 1'b0, "+0000000000000000000000-", "........................"},
        '{"R10", 2'b11, 1'b1, "+00000000000000000000-",   "........^............."}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       pos_in = 1'b0;
    logic       neg_in = 1'b0;
    logic [1:0] code_sel = 2'b00;
    logic       exz_en = 1'b0;
    logic       viol_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    byte sym [32];
    byte ex  [32];
    int  len;

    always #2 clk = ~clk;   // 250 MHz

    lcv_detector uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .pos_in   (pos_in),
        .neg_in   (neg_in),
        .code_sel (code_sel),
        .exz_en   (exz_en),
        .viol_o   (viol_o)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        bit_en = 1'b0;
        pos_in = 1'b0;
        neg_in = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic drive_sym(input byte c);
        pos_in = (c == "+") || (c == "*");
        neg_in = (c == "-") || (c == "*");
    endtask

    // One strobed bit; returns the output seen just after the edge.
    task automatic step(input byte c, input logic [1:0] md, input logic ez,
                        output logic v);
        @(negedge clk);
        drive_sym(c);
        code_sel = md;
        exz_en   = ez;
        bit_en   = 1'b1;
        @(posedge clk);
        #1;
        v = viol_o;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic        v;
        logic [31:0] got;
        logic [31:0] expm;
        int          pulses;
        int          hit_at;

        // R12: output low during reset with violating marks driven.
        rst_n    = 1'b0;
        code_sel = 2'b10;
        repeat (3) begin
            @(negedge clk);
            pos_in = 1'b1;
            bit_en = 1'b1;
            @(posedge clk);
            #1;
            check(viol_o == 1'b0, "R12 during reset", {31'd0, viol_o}, 32'd0);
        end
        do_reset();
        #1;
        check(viol_o == 1'b0, "R12 after reset", {31'd0, viol_o}, 32'd0);

        // Vector table.
        for (int vi = 0; vi < NV; vi++) begin
            len = 0;
            for (int b = 31; b >= 0; b--) begin
                byte c;
                c = VECS[vi].pat[b*8 +: 8];
                if (c != 0) begin
                    sym[len] = c;
                    ex[len]  = VECS[vi].exp[b*8 +: 8];
                    len++;
                end
            end
            do_reset();
            got  = '0;
            expm = '0;
            for (int i = 0; i < len; i++)
                if (ex[i] == "^") expm[i] = 1'b1;
            for (int j = 0; j < len + DLY; j++) begin
                if (j < len)
                    step(sym[j], VECS[vi].md, VECS[vi].ez, v);
                else
                    step("0", 2'b00, 1'b0, v);
                if (v) begin
                    if (j >= DLY) got[j-DLY] = 1'b1;
                    else          got[31]    = 1'b1;
                end
            end
            @(negedge clk);
            bit_en = 1'b0;
            check(got == expm, string'(VECS[vi].tag), got, expm);
        end

        // R11: strobes with idle gaps; latency counted in strobes.
        do_reset();
        pulses = 0;
        hit_at = -1;
        for (int j = 0; j < 2 + DLY; j++) begin
            step(j < 2 ? "+" : "0", j < 2 ? 2'b10 : 2'b00, 1'b0, v);
            if (v) begin pulses++; hit_at = j; end
            @(negedge clk);
            bit_en = 1'b0;
            repeat (2) begin
                @(posedge clk);
                #1;
                if (viol_o) pulses = pulses + 100;
                @(negedge clk);
            end
        end
        check(pulses == 1, "R11 pulse count with gaps", pulses, 1);
        check(hit_at == 1 + DLY, "R11 pulse strobe index", hit_at, 1 + DLY);

        // R12: reset discards a pending flag.
        do_reset();
        step("+", 2'b10, 1'b0, v);
        step("+", 2'b10, 1'b0, v);
        do_reset();
        pulses = 0;
        for (int j = 0; j < DLY + 2; j++) begin
            step("0", 2'b00, 1'b0, v);
            if (v) pulses++;
        end
        @(negedge clk);
        bit_en = 1'b0;
        check(pulses == 0, "R12 pending flag cleared", pulses, 0);

        // R3: after reset the first mark again passes, repeated one flagged.
        do_reset();
        got = '0;
        for (int j = 0; j < 2 + DLY; j++) begin
            step(j < 2 ? "-" : "0", j < 2 ? 2'b11 : 2'b00, 1'b0, v);
            if (v && j >= DLY) got[j-DLY] = 1'b1;
        end
        @(negedge clk);
        bit_en = 1'b0;
        check(got == 32'h2, "R3 first mark in B8ZS", got, 32'h2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule